// File: doc/BRIEF.md
# Edge/Level Interrupt Controller

This block collects up to 64 interrupt request lines and funnels them onto a smaller set of parent interrupt outputs. Each source is set to edge or level mode. The block keeps a pending bit and an in-service bit for every source, and a mask bit gates delivery. A per-source vector byte picks the parent line that the source drives. A source whose vector names a line that does not exist is tracked but drives nothing.

Software reaches the block over a simple 32-bit register bus. A write happens in the cycle that `busWr` is high. Reads are combinational from the current register state. Each 64-bit register is split into a low word and a high word. In every clock cycle, the input transitions seen in that cycle are handled first. Any bus write in the same cycle then acts on the resulting state.

Top module: `picController`

## Requirements
- R1: After reset, every mask bit reads 1. Edge-select, pending, in-service, polarity and status read 0, every vector byte reads 0 and every route byte reads 1.
- R2: In edge mode, a low-to-high input transition marks the source pending. A high-to-low transition leaves the pending bit set, so the in-service bit and the parent line stay up.
- R3: In level mode, the pending bit is set while the input is high and cleared when it falls.
- R4: When an input rises on an unmasked source, that source's in-service bit is set and the parent line numbered by its vector byte is asserted. A vector value of NUM_OUT or more asserts no line.
- R5: When an input falls and its source is in service but no longer pending, the in-service bit is cleared and the parent line named by the vector byte is deasserted.
- R6: A write to the clear word (0x030 low, 0x034 high) acts only if at least one written bit is edge-mode. It then drops those bits from pending, deasserts the line of the lowest-numbered written source that was in service, and drops the written bits from in-service. Otherwise it changes nothing.
- R7: A mask write (0x020 low, 0x024 high) runs two evaluations on the changed bits. For bits that became unmasked and are pending, only the lowest-numbered one is raised. For bits that became masked and are in service but not pending, only the lowest-numbered one is lowered.
- R8: The status word (0x040/0x044) reads as in-service AND NOT mask. Writing it replaces that half of the in-service state.
- R9: Writing one half of a 64-bit register (mask, edge-select at 0x028/0x02C, polarity at 0x048/0x04C) leaves the other half unchanged.
- R10: The identification low word (0x000) reads ID_WORD. The high word (0x004) reads VERSION in bits 15:0 and NUM_SRC-1 in bits 31:16.
- R11: Polarity and route bytes (0x200+n) are plain storage that never alter delivery. Vector bytes live at 0x100+n, with data in bits 7:0. Reads from unmapped addresses return 0, and writes to them are ignored.
- R12: Within one cycle, a bus write acts after the input events. If input events set and clear the same parent line in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_SRC | Interrupt request inputs, sampled every clock |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 12 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| irqOut | output | NUM_OUT | Parent interrupt lines |

## Verification
The bench targets the corner cases most likely to be wrong:
- An edge source whose input falls must stay up. A design that treats it like a level source would drop the parent line on the fall and lose the interrupt.
- Unmasking two pending sources at once must raise only the lower one. A design that raises every unmasked source would assert both lines.
- A clear word that holds only level-mode bits must change nothing. A design missing this guard would wrongly clear the in-service state.
- A clear in the same cycle as a rising edge checks the ordering. A design that applies the bus before the inputs would leave the line asserted after that cycle.
- A rise and a fall that share one parent line check that the set wins. A design with the opposite priority would leave the line low.

// File: rtl/picPkg.sv
package picPkg;
  localparam int MAXSRC = 64;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_IDLO, SEL_IDHI, SEL_MASK, SEL_EDGE,
    SEL_CLR, SEL_STAT, SEL_POL, SEL_VEC, SEL_ROUTE
  } regSelT;

  typedef struct packed {
    logic        wr;
    regSelT      sel;
    logic        hi;
    logic [5:0]  idx;
    logic [31:0] data;
  } busStrobeT;

  function automatic logic [63:0] lowestOf(input logic [63:0] v);
    return v & (~v + 64'd1);
  endfunction

  function automatic logic [63:0] mergeHalf(input logic [63:0] cur, input logic hi,
                                            input logic [31:0] d);
    return hi ? {d, cur[31:0]} : {cur[63:32], d};
  endfunction
endpackage

// File: rtl/picBusDecode.sv
module picBusDecode
  import picPkg::*;
(
  input  logic        busWr,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWdata,
  output busStrobeT   stb
);
  always_comb begin
    stb.wr   = busWr;
    stb.data = busWdata;
    stb.hi   = busAddr[2];
    stb.idx  = busAddr[5:0];
    stb.sel  = SEL_NONE;
    if (busAddr[11:6] == 6'b000100) stb.sel = SEL_VEC;
    else if (busAddr[11:6] == 6'b001000) stb.sel = SEL_ROUTE;
    else if (busAddr[1:0] == 2'b00) begin
      case (busAddr[11:3])
        9'h000:  stb.sel = busAddr[2] ? SEL_IDHI : SEL_IDLO;
        9'h004:  stb.sel = SEL_MASK;
        9'h005:  stb.sel = SEL_EDGE;
        9'h006:  stb.sel = SEL_CLR;
        9'h008:  stb.sel = SEL_STAT;
        9'h009:  stb.sel = SEL_POL;
        default: stb.sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/picCore.sv
module picCore
  import picPkg::*;
#(
  parameter int          NUM_SRC = 64,
  parameter int          NUM_OUT = 8,
  parameter logic [15:0] VERSION = 16'h0001,
  parameter logic [31:0] ID_WORD = 32'h7069_6301
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [63:0]        irqPad,
  input  busStrobeT          stb,
  output logic [31:0]        rdata,
  output logic [NUM_OUT-1:0] irqOut
);
  localparam logic [63:0] VALID = (NUM_SRC >= 64) ? '1 : ((64'd1 << NUM_SRC) - 64'd1);

  logic [63:0] maskR, edgeR, pendR, isrR, lastR, polR;
  logic [7:0]  vecR   [MAXSRC];
  logic [7:0]  routeR [MAXSRC];

  logic [63:0] rise, fall, pendA, riseHit, fallHit, isrA;
  logic [63:0] maskN, edgeN, pendN, isrN, polN, busUp, busDn, wrData64;
  logic [63:0] lineMap [NUM_OUT];
  logic [NUM_OUT-1:0] lineN;
  logic idxOk;

  assign idxOk    = int'(stb.idx) < NUM_SRC;
  assign wrData64 = (stb.hi ? {stb.data, 32'h0} : {32'h0, stb.data}) & VALID;

  always_comb begin
    for (int l = 0; l < NUM_OUT; l++)
      for (int i = 0; i < MAXSRC; i++)
        lineMap[l][i] = VALID[i] && (vecR[i] == 8'(l));
  end

  // input events first
  always_comb begin
    rise    = irqPad & ~lastR;
    fall    = ~irqPad & lastR;
    pendA   = (pendR | rise) & ~(fall & ~edgeR);
    riseHit = rise & ~maskR;
    fallHit = fall & isrR & ~pendA;
    isrA    = (isrR | riseHit) & ~fallHit;
  end

  // bus write acts on post-event state
  always_comb begin
    maskN = maskR; edgeN = edgeR; pendN = pendA; isrN = isrA; polN = polR;
    busUp = '0; busDn = '0;
    if (stb.wr) begin
      case (stb.sel)
        SEL_MASK: begin
          maskN = mergeHalf(maskR, stb.hi, stb.data) | ~VALID;
          busUp = lowestOf(maskR & ~maskN & pendA & ~maskN);
          busDn = lowestOf(~maskR & maskN & isrA & ~pendA);
          isrN  = (isrA | busUp) & ~busDn;
        end
        SEL_EDGE: edgeN = mergeHalf(edgeR, stb.hi, stb.data) & VALID;
        SEL_CLR: if ((wrData64 & edgeR) != 64'd0) begin
          pendN = pendA & ~wrData64;
          busDn = lowestOf(wrData64 & isrA & ~pendN);
          isrN  = isrA & ~wrData64;
        end
        SEL_STAT: isrN = mergeHalf(isrA, stb.hi, stb.data) & VALID;
        SEL_POL:  polN = mergeHalf(polR, stb.hi, stb.data) & VALID;
        default: ;
      endcase
    end
  end

  always_comb begin
    lineN = '0;
    for (int l = 0; l < NUM_OUT; l++)
      lineN[l] = ((irqOut[l] & ~(|(fallHit & lineMap[l]))) | (|(riseHit & lineMap[l]))
                  | (|(busUp & lineMap[l]))) & ~(|(busDn & lineMap[l]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskR <= '1; edgeR <= '0; pendR <= '0; isrR <= '0; lastR <= '0; polR <= '0;
      irqOut <= '0;
      for (int i = 0; i < MAXSRC; i++) begin
        vecR[i]   <= 8'd0;
        routeR[i] <= 8'd1;
      end
    end else begin
      maskR <= maskN; edgeR <= edgeN; pendR <= pendN; isrR <= isrN; polR <= polN;
      lastR <= irqPad & VALID;
      irqOut <= lineN;
      if (stb.wr && idxOk && stb.sel == SEL_VEC)   vecR[stb.idx]   <= stb.data[7:0];
      if (stb.wr && idxOk && stb.sel == SEL_ROUTE) routeR[stb.idx] <= stb.data[7:0];
    end
  end

  logic [63:0] visible;
  assign visible = isrR & ~maskR;

  always_comb begin
    case (stb.sel)
      SEL_IDLO:  rdata = ID_WORD;
      SEL_IDHI:  rdata = {16'(NUM_SRC - 1), VERSION};
      SEL_MASK:  rdata = stb.hi ? maskR[63:32]   : maskR[31:0];
      SEL_EDGE:  rdata = stb.hi ? edgeR[63:32]   : edgeR[31:0];
      SEL_STAT:  rdata = stb.hi ? visible[63:32] : visible[31:0];
      SEL_POL:   rdata = stb.hi ? polR[63:32]    : polR[31:0];
      SEL_VEC:   rdata = idxOk ? {24'h0, vecR[stb.idx]}   : 32'h0;
      SEL_ROUTE: rdata = idxOk ? {24'h0, routeR[stb.idx]} : 32'h0;
      default:   rdata = 32'h0;
    endcase
  end

  // R8: masked sources never show in status
  a_r8_status_hides_masked: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sel == SEL_STAT) |-> ((rdata & (stb.hi ? maskR[63:32] : maskR[31:0])) == 32'h0));

  // R2: edge pending survives anything but a clear write
  a_r2_edge_pending_held: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wr && stb.sel == SEL_CLR) |=> (($past(pendR) & $past(edgeR) & ~pendR) == 64'd0));

  // R4: in-service only newly set for unmasked sources
  a_r4_service_unmasked: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wr && stb.sel == SEL_STAT) |=> (((isrR & ~$past(isrR)) & maskR & $past(maskR)) == 64'd0));

  // R6: clear without edge bits and with quiet inputs changes nothing
  a_r6_clear_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr && stb.sel == SEL_CLR && (wrData64 & edgeR) == 64'd0 && (irqPad & VALID) == lastR)
      |=> ($stable(pendR) && $stable(isrR)));

  // R12: a parent line moves only after an input event or a bus write
  a_r12_line_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(irqOut)) || $past(stb.wr) || ($past(irqPad & VALID) != $past(lastR)));
endmodule

// File: rtl/picController.sv
module picController
  import picPkg::*;
#(
  parameter int          NUM_SRC = 64,
  parameter int          NUM_OUT = 8,
  parameter logic [15:0] VERSION = 16'h0001,
  parameter logic [31:0] ID_WORD = 32'h7069_6301
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               busWr,
  input  logic [11:0]        busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic [NUM_OUT-1:0] irqOut
);
  busStrobeT   stb;
  logic [63:0] irqPad;

  assign irqPad = 64'(irqIn);

  picBusDecode decode_i (
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .stb(stb)
  );

  picCore #(
    .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .VERSION(VERSION), .ID_WORD(ID_WORD)
  ) core_i (
    .clk(clk), .rstN(rstN), .irqPad(irqPad), .stb(stb), .rdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/picController_tb_top.sv
module picController_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqIn = '0;
  logic        busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  irqOut;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  picController dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // behavioural reference state
  logic [63:0] mMask, mEdge, mPend, mIsr, mLast, mPol;
  logic [7:0]  mVec [64];
  logic [7:0]  mRoute [64];
  logic [7:0]  mOut;
  logic [63:0] curIn = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lowIdx(input logic [63:0] v);
    for (int k = 0; k < 64; k++) if (v[k]) return k;
    return -1;
  endfunction

  task automatic modelReset();
    mMask = '1; mEdge = '0; mPend = '0; mIsr = '0; mLast = '0; mPol = '0; mOut = '0;
    for (int i = 0; i < 64; i++) begin mVec[i] = 8'd0; mRoute[i] = 8'd1; end
  endtask

  task automatic modelTick(input logic [63:0] inp, input bit wr, input logic [11:0] a, input logic [31:0] d);
    logic [7:0] setL, clrL;
    logic [63:0] d64, old, up, dn;
    int k;
    setL = '0; clrL = '0;
    for (int i = 0; i < 64; i++) begin
      if (inp[i] && !mLast[i]) begin
        mLast[i] = 1'b1; mPend[i] = 1'b1;
        if (!mMask[i]) begin mIsr[i] = 1'b1; if (mVec[i] < 8) setL[mVec[i][2:0]] = 1'b1; end
      end else if (!inp[i] && mLast[i]) begin
        mLast[i] = 1'b0;
        if (!mEdge[i]) mPend[i] = 1'b0;
        if (mIsr[i] && !mPend[i]) begin mIsr[i] = 1'b0; if (mVec[i] < 8) clrL[mVec[i][2:0]] = 1'b1; end
      end
    end
    mOut = (mOut & ~clrL) | setL;
    if (!wr) return;
    d64 = a[2] ? {d, 32'h0} : {32'h0, d};
    if (a >= 12'h100 && a < 12'h140) mVec[a - 12'h100] = d[7:0];
    else if (a >= 12'h200 && a < 12'h240) mRoute[a - 12'h200] = d[7:0];
    else case (a)
      12'h020, 12'h024: begin
        old = mMask;
        if (a[2]) mMask[63:32] = d; else mMask[31:0] = d;
        up = old & ~mMask & mPend & ~mMask;
        k = lowIdx(up);
        if (k >= 0) begin mIsr[k] = 1'b1; if (mVec[k] < 8) mOut[mVec[k][2:0]] = 1'b1; end
        dn = ~old & mMask & mIsr & ~mPend;
        k = lowIdx(dn);
        if (k >= 0) begin mIsr[k] = 1'b0; if (mVec[k] < 8) mOut[mVec[k][2:0]] = 1'b0; end
      end
      12'h028: mEdge[31:0] = d;
      12'h02C: mEdge[63:32] = d;
      12'h030, 12'h034: if ((mEdge & d64) != 0) begin
        mPend = mPend & ~d64;
        k = lowIdx(d64 & mIsr & ~mPend);
        if (k >= 0 && mVec[k] < 8) mOut[mVec[k][2:0]] = 1'b0;
        mIsr = mIsr & ~d64;
      end
      12'h040: mIsr[31:0] = d;
      12'h044: mIsr[63:32] = d;
      12'h048: mPol[31:0] = d;
      12'h04C: mPol[63:32] = d;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    logic [63:0] vis;
    vis = mIsr & ~mMask;
    if (a >= 12'h100 && a < 12'h140) return {24'h0, mVec[a - 12'h100]};
    if (a >= 12'h200 && a < 12'h240) return {24'h0, mRoute[a - 12'h200]};
    case (a)
      12'h000: return 32'h7069_6301;
      12'h004: return {16'd63, 16'h0001};
      12'h020: return mMask[31:0];
      12'h024: return mMask[63:32];
      12'h028: return mEdge[31:0];
      12'h02C: return mEdge[63:32];
      12'h040: return vis[31:0];
      12'h044: return vis[63:32];
      12'h048: return mPol[31:0];
      12'h04C: return mPol[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic cyc(input logic [63:0] inp, input bit wr, input logic [11:0] a,
                     input logic [31:0] d, input string tag);
    logic [31:0] er;
    @(negedge clk);
    irqIn = inp; busWr = wr; busAddr = a; busWdata = d; curIn = inp;
    #1;
    er = modelRead(a);
    chk(busRdata === er, {tag, " rdata"}, 64'(busRdata), 64'(er));
    @(posedge clk);
    modelTick(inp, wr, a, d);
    #1;
    chk(irqOut === mOut, {tag, " irqOut"}, 64'(irqOut), 64'(mOut));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(curIn, 1'b1, a, d, tag);
  endtask

  task automatic rdExpect(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busWr = 1'b0; busAddr = a;
    #1;
    chk(busRdata === exp, tag, 64'(busRdata), 64'(exp));
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset values
    rdExpect(12'h020, 32'hFFFF_FFFF, "R1 mask lo");
    rdExpect(12'h024, 32'hFFFF_FFFF, "R1 mask hi");
    rdExpect(12'h028, 32'h0, "R1 edge");
    rdExpect(12'h040, 32'h0, "R1 status");
    rdExpect(12'h10A, 32'h0, "R1 vector");
    rdExpect(12'h205, 32'h1, "R1 route");
    chk(irqOut === 8'h0, "R1 irqOut", 64'(irqOut), 64'h0);
    // R10 identification
    rdExpect(12'h004, {16'd63, 16'h0001}, "R10 id hi");
    rdExpect(12'h000, 32'h7069_6301, "R10 id lo");

    // vectors: src3,5 -> line2, src10 -> line7, src40 -> line9 (absent)
    wr(12'h103, 32'd2, "R11 vec3");
    wr(12'h105, 32'd2, "R11 vec5");
    wr(12'h10A, 32'd7, "R11 vec10");
    wr(12'h128, 32'd9, "R11 vec40");
    wr(12'h020, ~32'h0000_0428, "R9 mask lo");
    wr(12'h024, ~32'h0000_0100, "R9 mask hi");
    rdExpect(12'h020, ~32'h0000_0428, "R9 mask lo kept");
    rdExpect(12'h024, ~32'h0000_0100, "R9 mask hi kept");
    wr(12'h028, 32'h0000_0008, "R9 edge lo");
    wr(12'h02C, 32'h0000_0100, "R9 edge hi");
    rdExpect(12'h028, 32'h0000_0008, "R9 edge lo kept");

    // R2/R4 edge source 3
    cyc(64'h8, 0, 12'h040, 0, "R4 edge rise");
    chk(irqOut[2] === 1'b1, "R4 line2 up", 64'(irqOut), 64'h4);
    cyc(64'h0, 0, 12'h040, 0, "R2 edge fall");
    chk(irqOut[2] === 1'b1, "R2 line2 held", 64'(irqOut), 64'h4);
    rdExpect(12'h040, 32'h8, "R2 status held");
    // R6 clear only level bit: no effect
    wr(12'h030, 32'h20, "R6 level-only clear");
    chk(irqOut[2] === 1'b1, "R6 no effect", 64'(irqOut), 64'h4);
    wr(12'h030, 32'h8, "R6 edge clear");
    chk(irqOut[2] === 1'b0, "R6 line2 dropped", 64'(irqOut), 64'h0);

    // R3/R5 level sources 5 and 10
    cyc(64'h420, 0, 12'h040, 0, "R3 level rise");
    chk(irqOut === 8'h84, "R3 lines up", 64'(irqOut), 64'h84);
    cyc(64'h400, 0, 12'h040, 0, "R5 level fall");
    chk(irqOut === 8'h80, "R5 line2 down", 64'(irqOut), 64'h80);
    cyc(64'h0, 0, 12'h040, 0, "R5 fall 10");

    // R4 vector out of range: src40 tracked, no line
    cyc(64'h100_0000_0000, 0, 12'h044, 0, "R4 absent line");
    chk(irqOut === 8'h0, "R4 no line", 64'(irqOut), 64'h0);
    rdExpect(12'h044, 32'h100, "R4 src40 in service");
    wr(12'h034, 32'h100, "R6 clear hi");
    cyc(64'h0, 0, 12'h044, 0, "R6 hi after");

    // R7: mask all, raise 5 and 10, unmask both -> only lowest
    wr(12'h020, 32'hFFFF_FFFF, "R7 mask all");
    cyc(64'h420, 0, 12'h040, 0, "R7 masked rise");
    chk(irqOut === 8'h0, "R7 masked nothing", 64'(irqOut), 64'h0);
    wr(12'h020, ~32'h0000_0420, "R7 unmask two");
    chk(irqOut === 8'h04, "R7 lowest only", 64'(irqOut), 64'h04);
    cyc(64'h0, 0, 12'h040, 0, "R7 fall");
    // re-mask with source in service but not pending
    wr(12'h020, ~32'h0000_0428, "R7 restore");
    wr(12'h040, 32'h0000_0020, "R8 status write");
    rdExpect(12'h040, 32'h20, "R8 status readback");
    wr(12'h020, ~32'h0000_0408, "R7 mask src5");
    rdExpect(12'h040, 32'h0, "R8 masked hidden");

    // R11 polarity and route are storage only
    wr(12'h048, 32'hDEAD_BEEF, "R11 polarity lo");
    wr(12'h04C, 32'h1234_5678, "R11 polarity hi");
    rdExpect(12'h048, 32'hDEAD_BEEF, "R11 polarity lo kept");
    wr(12'h203, 32'h5A, "R11 route3");
    rdExpect(12'h203, 32'h5A, "R11 route readback");
    wr(12'h3F0, 32'hFFFF_FFFF, "R11 unmapped write");
    rdExpect(12'h3F0, 32'h0, "R11 unmapped read");
    rdExpect(12'h020, ~32'h0000_0408, "R11 unmapped no effect");
    cyc(64'h8, 0, 12'h040, 0, "R11 rise after storage");
    chk(irqOut[2] === 1'b1, "R11 delivery unchanged", 64'(irqOut), 64'h4);

    // R12 ordering: fall of edge src3 ignored; clear with rise in same cycle
    cyc(64'h0, 1, 12'h030, 32'h8, "R12 clear");
    cyc(64'h8, 1, 12'h030, 32'h8, "R12 rise+clear");
    chk(irqOut[2] === 1'b0, "R12 bus after input", 64'(irqOut), 64'h0);
    // set wins: unmask 5 again, raise 5, then rise 3 with fall 5 same cycle
    wr(12'h020, ~32'h0000_0428, "R12 unmask");
    cyc(64'h0, 0, 12'h040, 0, "R12 drop3");
    cyc(64'h20, 0, 12'h040, 0, "R12 rise5");
    cyc(64'h8, 0, 12'h040, 0, "R12 rise3 fall5");
    chk(irqOut[2] === 1'b1, "R12 set wins", 64'(irqOut), 64'h4);
    cyc(64'h0, 0, 12'h040, 0, "R12 tail");

    finish();
  end
endmodule